// File: doc/BRIEF.md
# Edge-Driven Event Counter with Wrap Interrupt

This block watches the most significant pin of an 8-bit input port and counts its transitions in an 8-bit accumulator. An edge-polarity control picks whether low-to-high or high-to-low transitions count. Counting runs only when the block is enabled and the mode control selects event counting. The other setting, gated timing, is recognised but only stops the count. When an increment takes the accumulator from all ones back to zero, an overflow flag is set. An interrupt request follows that flag whenever the overflow interrupt enable is high.

The block also keeps the port's input latch. A per-bit input mask decides which external bits the latch takes in. The two lowest bits are always inputs. The top bit is an input only while its direction control marks it as an input. The bits in between are never taken in and keep their reset value of zero. A transition is recognised only when the latched top bit changes. The host can load the accumulator at any time, and can clear the overflow flag by pulsing a clear strobe.

A small state machine registers the configuration once per clock. Its four states are `PA_IDLE` (disabled), `PA_GATED` (enabled in gated-time mode, no counting), `PA_RISE` (counting rising transitions) and `PA_FALL` (counting falling transitions). On every clock it moves to the state chosen by the control inputs sampled at that edge:
- `acc_enable` low selects `PA_IDLE`.
- Otherwise `acc_gated` high selects `PA_GATED`.
- Otherwise `edge_rising` chooses between `PA_RISE` and `PA_FALL`.

Any state can reach any other in a single clock.

Top module: `pacc_event_counter`

## Requirements
- R1: After reset, `acc_count` is 0x00, `ovf_flag` and `ovf_irq` are 0, `port_level` is 0x00, and the state machine is in `PA_IDLE`.
- R2: Counting is active only when `acc_enable`=1 and `acc_gated`=0. These controls are registered, so a change applies to pin transitions latched from the following clock onward.
- R3: In counting mode, `edge_rising`=1 counts latched top-bit transitions from 0 to 1, and `edge_rising`=0 counts transitions from 1 to 0. Each counted transition adds 1 to `acc_count` at the same clock edge that latches the new pin value.
- R4: `acc_count` changes without a host load only on a clock where `port_level[7]` changes. Changes on other bits never count.
- R5: The input mask is 0x83 when `top_is_output`=0 and 0x03 when `top_is_output`=1. Masked-in bits of `port_in` are latched into `port_level` on each clock. Masked-out bits hold, so `port_level[7]` holds while the top pin is an output, and `port_level[6:2]` stays 0.
- R6: `ovf_flag` is set when an increment moves `acc_count` from 0xFF to 0x00. A host load of 0x00 does not set it.
- R7: A host load (`cnt_load`=1) writes `cnt_load_val` into `acc_count` and overrides an increment in the same clock. That increment is lost and cannot set the flag.
- R8: `ovf_clear`=1 clears `ovf_flag` at the next clock edge. If an overflow occurs in that same clock, the flag ends up set.
- R9: `ovf_irq` equals `ovf_flag` AND `ovf_irq_en`.
- R10: In gated-time mode (`acc_enable`=1, `acc_gated`=1), and while disabled, pin transitions leave `acc_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | 8 | External levels of the port pins |
| top_is_output | input | 1 | 1 marks the top pin as an output, masking it out of the latch |
| acc_enable | input | 1 | Accumulator enable |
| acc_gated | input | 1 | 1 selects gated-time mode, 0 selects event counting |
| edge_rising | input | 1 | 1 counts rising transitions, 0 counts falling |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| cnt_load | input | 1 | Host load strobe for the accumulator |
| cnt_load_val | input | 8 | Value written by a host load |
| ovf_clear | input | 1 | Write-one strobe that clears the overflow flag |
| port_level | output | 8 | Latched port value after masking |
| acc_count | output | 8 | Accumulator value |
| ovf_flag | output | 1 | Overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench targets the one-clock configuration latency: a transition arriving in the same clock as the enable must not count. A design that combined the controls without registering them would count it one time too many. The bench drives a host load together with a counted edge at 0xFF and at other values. A design that let the increment win would show a value off by one or a spurious flag. The bench also drives a top-pin toggle while the pin is an output, and a flag clear in the same clock as a wrap. A design that ignored the mask would count phantom edges, and one that gave the clear priority would lose an overflow.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    typedef enum logic [1:0] {
        PA_IDLE  = 2'd0,
        PA_GATED = 2'd1,
        PA_RISE  = 2'd2,
        PA_FALL  = 2'd3
    } pa_state_e;
endpackage

// File: rtl/pacc_port_latch.sv
module pacc_port_latch #(
    parameter int PORT_W = 8,
    parameter int LOW_IN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_in,
    input  logic              top_is_output,
    output logic [PORT_W-1:0] port_q,
    output logic              top_rose,
    output logic              top_fell
);
    localparam logic [PORT_W-1:0] LOW_MASK = {{(PORT_W-LOW_IN){1'b0}}, {LOW_IN{1'b1}}};
    localparam logic [PORT_W-1:0] TOP_MASK = {1'b1, {(PORT_W-1){1'b0}}};

    logic [PORT_W-1:0] in_mask;
    logic [PORT_W-1:0] port_nxt;

    always_comb begin
        in_mask  = top_is_output ? LOW_MASK : (LOW_MASK | TOP_MASK);
        port_nxt = (port_in & in_mask) | (port_q & ~in_mask);
        top_rose = port_nxt[PORT_W-1] & ~port_q[PORT_W-1];
        top_fell = ~port_nxt[PORT_W-1] & port_q[PORT_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_nxt;
    end

    // R5: an output-direction top pin keeps its latched level
    a_r5_top_held_as_output: assert property (@(posedge clk) disable iff (!rst_n)
        top_is_output |=> (port_q[PORT_W-1] == $past(port_q[PORT_W-1])));
endmodule

// File: rtl/pacc_mode_fsm.sv
module pacc_mode_fsm
    import pacc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_enable,
    input  logic acc_gated,
    input  logic edge_rising,
    output logic cnt_on,
    output logic want_high
);
    pa_state_e state_q, state_d;

    always_comb begin
        if (!acc_enable)     state_d = PA_IDLE;
        else if (acc_gated)  state_d = PA_GATED;
        else if (edge_rising) state_d = PA_RISE;
        else                 state_d = PA_FALL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PA_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cnt_on    = 1'b0;
        want_high = 1'b0;
        unique case (state_q)
            PA_IDLE:  ;
            PA_GATED: ;
            PA_RISE:  begin cnt_on = 1'b1; want_high = 1'b1; end
            PA_FALL:  cnt_on = 1'b1;
            default:  ;
        endcase
    end

    // R2: disabling forces the idle state on the next clock
    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_enable |=> (state_q == PA_IDLE) && !cnt_on);
    // R10: gated-time mode never counts
    a_r10_gated_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_enable && acc_gated) |=> !cnt_on);
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_on,
    input  logic             want_high,
    input  logic             top_rose,
    input  logic             top_fell,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_load_val,
    input  logic             ovf_clear,
    input  logic             ovf_irq_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_flag,
    output logic             ovf_irq
);
    logic inc;
    logic wrap;

    always_comb begin
        inc  = cnt_on & (want_high ? top_rose : top_fell);
        wrap = inc & ~cnt_load & (cnt_q == '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_load) cnt_q <= cnt_load_val;
        else if (inc)      cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ovf_flag <= 1'b0;
        else if (wrap)      ovf_flag <= 1'b1;
        else if (ovf_clear) ovf_flag <= 1'b0;
    end

    assign ovf_irq = ovf_flag & ovf_irq_en;

    // R6: the flag rises only from an unloaded increment at all ones
    a_r6_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cnt_q) == '1) && $past(inc) && !$past(cnt_load));
    // R7: a load always lands, whatever the pin did
    a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (cnt_q == $past(cnt_load_val)));
    // R8: a clear with no increment leaves the flag low
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clear && !inc) |=> !ovf_flag);
endmodule

// File: rtl/pacc_event_counter.sv
module pacc_event_counter #(
    parameter int PORT_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_in,
    input  logic              top_is_output,
    input  logic              acc_enable,
    input  logic              acc_gated,
    input  logic              edge_rising,
    input  logic              ovf_irq_en,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  cnt_load_val,
    input  logic              ovf_clear,
    output logic [PORT_W-1:0] port_level,
    output logic [CNT_W-1:0]  acc_count,
    output logic              ovf_flag,
    output logic              ovf_irq
);
    logic top_rose, top_fell, cnt_on, want_high;

    pacc_port_latch #(.PORT_W(PORT_W), .LOW_IN(2)) u_latch (
        .clk(clk), .rst_n(rst_n), .port_in(port_in), .top_is_output(top_is_output),
        .port_q(port_level), .top_rose(top_rose), .top_fell(top_fell)
    );

    pacc_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .acc_enable(acc_enable), .acc_gated(acc_gated),
        .edge_rising(edge_rising), .cnt_on(cnt_on), .want_high(want_high)
    );

    pacc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_on(cnt_on), .want_high(want_high),
        .top_rose(top_rose), .top_fell(top_fell), .cnt_load(cnt_load),
        .cnt_load_val(cnt_load_val), .ovf_clear(ovf_clear), .ovf_irq_en(ovf_irq_en),
        .cnt_q(acc_count), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
    );

    // R4: an unloaded count change needs a top-bit transition
    a_r4_count_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_count != $past(acc_count)) && !$past(cnt_load)) |-> $past(top_rose || top_fell));
endmodule

// File: tb/tb_pacc_event_counter.sv
module tb_pacc_event_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] port_in = 8'h00;
    logic       top_is_output = 1'b0, acc_enable = 1'b0, acc_gated = 1'b0;
    logic       edge_rising = 1'b0, ovf_irq_en = 1'b0, cnt_load = 1'b0, ovf_clear = 1'b0;
    logic [7:0] cnt_load_val = 8'h00;
    logic [7:0] port_level, acc_count;
    logic       ovf_flag, ovf_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    pacc_event_counter dut (
        .clk(clk), .rst_n(rst_n), .port_in(port_in), .top_is_output(top_is_output),
        .acc_enable(acc_enable), .acc_gated(acc_gated), .edge_rising(edge_rising),
        .ovf_irq_en(ovf_irq_en), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
        .ovf_clear(ovf_clear), .port_level(port_level), .acc_count(acc_count),
        .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: mode 0 off, 1 gated, 2 rising, 3 falling
    int         m_mode;
    logic [7:0] m_port, m_cnt;
    bit         m_flag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_port = 8'h00; m_cnt = 8'h00; m_flag = 0;
        end else begin
            logic [7:0] msk, np;
            bit hit, wrapped;
            msk = top_is_output ? 8'h03 : 8'h83;
            np  = (port_in & msk) | (m_port & ~msk);
            hit = (m_mode == 2 && np[7] && !m_port[7]) || (m_mode == 3 && !np[7] && m_port[7]);
            wrapped = 0;
            if (cnt_load) m_cnt = cnt_load_val;
            else if (hit) begin
                m_cnt = m_cnt + 8'd1;
                wrapped = (m_cnt == 8'h00);
            end
            if (wrapped) m_flag = 1;
            else if (ovf_clear) m_flag = 0;
            m_mode = !acc_enable ? 0 : acc_gated ? 1 : edge_rising ? 2 : 3;
            m_port = np;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(port_level == m_port, "R5 port_level", port_level, m_port);
            chk(acc_count == m_cnt, "R3 acc_count", acc_count, m_cnt);
            chk(ovf_flag == m_flag, "R6 ovf_flag", ovf_flag, m_flag);
            chk(ovf_irq == (m_flag & ovf_irq_en), "R9 ovf_irq", ovf_irq, m_flag & ovf_irq_en);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse();
        port_in[7] = 1'b1; tick();
        port_in[7] = 1'b0; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(acc_count == 8'h00, "R1 count", acc_count, 0);
        chk(ovf_flag == 1'b0 && ovf_irq == 1'b0, "R1 flag", ovf_flag, 0);
        chk(port_level == 8'h00, "R1 port", port_level, 0);

        // R2: enable and an edge in the same clock does not count
        acc_enable = 1; edge_rising = 1; port_in[7] = 1; tick();
        chk(acc_count == 8'h00, "R2 latency", acc_count, 0);
        port_in[7] = 0; tick();
        for (int i = 0; i < 5; i++) pulse();
        chk(acc_count == 8'h05, "R3 rising", acc_count, 5);

        // R4: low bits toggle, no count
        for (int i = 0; i < 4; i++) begin port_in[1:0] = 2'(i); tick(); end
        chk(acc_count == 8'h05, "R4 other bits", acc_count, 5);

        // R3 falling
        cnt_load = 1; cnt_load_val = 8'h00; tick(); cnt_load = 0;
        edge_rising = 0; tick();
        for (int i = 0; i < 3; i++) pulse();
        chk(acc_count == 8'h03, "R3 falling", acc_count, 3);

        // R5 mask with the top pin as output
        top_is_output = 1; port_in = 8'hFE; tick();
        chk(port_level == 8'h02, "R5 mask output", port_level, 2);
        port_in = 8'h7E; tick();
        chk(acc_count == 8'h03, "R5 no phantom edge", acc_count, 3);
        port_in = 8'hFF; top_is_output = 0; tick();
        chk(port_level == 8'h83, "R5 mask input", port_level, 8'h83);
        port_in = 8'h00; tick();
        chk(acc_count == 8'h04, "R5 input edge counts", acc_count, 4);

        // R10 gated and disabled
        edge_rising = 1; acc_gated = 1; tick();
        pulse(); pulse();
        chk(acc_count == 8'h04, "R10 gated", acc_count, 4);
        acc_gated = 0; acc_enable = 0; tick();
        pulse();
        chk(acc_count == 8'h04, "R10 disabled", acc_count, 4);
        acc_enable = 1; tick();

        // R7 load beats increment
        cnt_load = 1; cnt_load_val = 8'h40; port_in[7] = 1; tick(); cnt_load = 0;
        port_in[7] = 0; tick();
        chk(acc_count == 8'h40, "R7 load wins", acc_count, 8'h40);

        // R6 wrap sets flag; R9 irq gating
        cnt_load = 1; cnt_load_val = 8'hFE; tick(); cnt_load = 0;
        pulse();
        chk(acc_count == 8'hFF && !ovf_flag, "R6 pre-wrap", acc_count, 8'hFF);
        pulse();
        chk(acc_count == 8'h00 && ovf_flag, "R6 wrap", {ovf_flag, acc_count}, 9'h100);
        chk(ovf_irq == 1'b0, "R9 masked", ovf_irq, 0);
        ovf_irq_en = 1; tick();
        chk(ovf_irq == 1'b1, "R9 enabled", ovf_irq, 1);

        // R8 clear, and set wins over clear
        ovf_clear = 1; tick(); ovf_clear = 0;
        chk(!ovf_flag && !ovf_irq, "R8 clear", ovf_flag, 0);
        cnt_load = 1; cnt_load_val = 8'hFF; tick(); cnt_load = 0;
        ovf_clear = 1; port_in[7] = 1; tick(); ovf_clear = 0;
        chk(ovf_flag == 1'b1, "R8 set wins", ovf_flag, 1);
        port_in[7] = 0; tick();
        ovf_clear = 1; tick(); ovf_clear = 0;

        // R6 load of zero and load over a wrapping edge leave the flag low
        cnt_load = 1; cnt_load_val = 8'h00; tick();
        cnt_load_val = 8'hFF; tick();
        cnt_load_val = 8'h00; port_in[7] = 1; tick(); cnt_load = 0;
        chk(acc_count == 8'h00 && !ovf_flag, "R6 load no flag", ovf_flag, 0);
        chk(ovf_flag == 1'b0, "R7 lost increment", ovf_flag, 0);
        port_in[7] = 0; tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule